// File: doc/BRIEF.md
# Edge-Pulse Encoder with Refresh

This block drives the sending side of a one-bit data link that crosses an isolation barrier. The link does not carry the input level continuously. It sends a one-cycle pulse on a set line when the synchronized input rises, and a one-cycle pulse on a clear line when it falls. A bistable receiver on the far side rebuilds the level from these pulses.

When the input holds its level for a programmable number of cycles, the block sends a refresh pulse on the line that matches the present level. It repeats this pulse at that interval for as long as the input stays still, so the receiver stays correct under a DC input.

A power-good input enables the block. While power-good is low the block emits nothing. On the cycle power-good rises, the block sends the current level at once.

Top module: `edge_pulse_tx`

## Requirements
- R1: A rising input is followed by exactly one `set_pulse_o` pulse, visible in the third clock cycle after the input changes (two synchronizer stages plus one output register).
- R2: A falling input is followed by exactly one `clr_pulse_o` pulse, with the same three-cycle latency as R1.
- R3: Every pulse is one cycle wide, and `set_pulse_o` and `clr_pulse_o` are never high in the same cycle, even when the input toggles on consecutive cycles.
- R4: While the input is idle and power-good is high, a refresh pulse appears IDLE_CYCLES cycles after the previous pulse and repeats with that period. The refresh uses `set_pulse_o` when the level is 1 and `clr_pulse_o` when it is 0.
- R5: Each edge pulse restarts the idle interval, so the next refresh comes IDLE_CYCLES cycles after that edge pulse.
- R6: While `pwr_good_i` is low, both pulse outputs stay low from the next cycle on, whatever the input does.
- R7: In the cycle after `pwr_good_i` rises, one pulse is emitted that carries the current synchronized level.
- R8: If an edge and a refresh fall due in the same cycle, a single pulse carrying the new level is emitted and the idle interval restarts from it.
- R9: While `rst_ni` is low, both pulse outputs are low, and they stay low until something starts a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| pwr_good_i | input | 1 | Supply-good enable; low suppresses all pulses |
| data_i | input | 1 | Asynchronous logic input to be sent |
| set_pulse_o | output | 1 | One-cycle pulse: remote receiver goes high |
| clr_pulse_o | output | 1 | One-cycle pulse: remote receiver goes low |

## Verification
The bench builds the block with IDLE_CYCLES set to 8 and two synchronizer stages. With an interval that short, several refresh periods fit into a few dozen cycles. It also makes it practical to place an input edge so that its pulse lands on exactly the cycle a refresh falls due, and to move an edge to the middle of an interval to show the restart. The fixed three-cycle latency lets every expected pulse be checked against an exact cycle number.

// File: rtl/ept_pkg.sv
// Shared types for the edge-pulse encoder.
// Assumes: a single clock domain after the input synchronizer.
package ept_pkg;

    // Reason a pulse is issued in a given cycle; the order is the priority.
    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_START   = 2'd1,
        EV_EDGE    = 2'd2,
        EV_REFRESH = 2'd3
    } ept_event_e;

endpackage

// File: rtl/ept_sync.sv
// Multi-stage synchronizer for one asynchronous bit.
// Assumes: STAGES >= 2; the reset value is 0.
module ept_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the input through the stage chain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ept_idle_timer.sv
// Idle interval counter. It counts enabled cycles since the last restart and
// flags due_o on the last cycle of the interval.
// Assumes: IDLE_CYCLES >= 4; restart_i is high in any cycle where a pulse is issued.
module ept_idle_timer #(
    parameter int IDLE_CYCLES = 100
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic restart_i,
    output logic due_o
);
    localparam int CNT_W = (IDLE_CYCLES > 2) ? $clog2(IDLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Clear on restart or power loss, otherwise count up.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !run_i || restart_i) cnt_q <= '0;
        else                                cnt_q <= cnt_q + 1'b1;
    end

    assign due_o = run_i && (cnt_q == LAST);

    // R4: the counter never runs past the end of the interval.
    p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);

    // R5: a restart always brings the count back to zero.
    p_restart_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/ept_pulse_gen.sv
// Chooses the pulse cause in each cycle (start-up, edge, refresh) and
// registers one set or clear pulse that carries the present level.
// Assumes: level_i is already synchronized; refresh_i comes from a register.
module ept_pulse_gen
    import ept_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pg_i,
    input  logic level_i,
    input  logic refresh_i,
    output logic fire_o,
    output logic set_o,
    output logic clr_o
);
    logic       lvl_q;
    logic       pg_q;
    ept_event_e ev;

    // Remember the last level and power state to detect changes.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lvl_q <= 1'b0;
            pg_q  <= 1'b0;
        end else begin
            lvl_q <= level_i;
            pg_q  <= pg_i;
        end
    end

    // Pick the pulse cause by priority; nothing fires while power is down.
    always_comb begin
        ev = EV_NONE;
        if (pg_i) begin
            if (!pg_q)                 ev = EV_START;
            else if (level_i != lvl_q) ev = EV_EDGE;
            else if (refresh_i)        ev = EV_REFRESH;
        end
    end

    assign fire_o = (ev != EV_NONE);

    // Register the pulse on the line that matches the level.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            set_o <= 1'b0;
            clr_o <= 1'b0;
        end else begin
            set_o <= fire_o &&  level_i;
            clr_o <= fire_o && !level_i;
        end
    end

    // R3: the two pulse lines are mutually exclusive.
    p_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(set_o && clr_o));

    // R3: set pulses are one cycle wide.
    p_set_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_o |=> !set_o);

    // R3: clear pulses are one cycle wide.
    p_clr_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_o |=> !clr_o);

    // R6: no output while power-good is low.
    p_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pg_i |=> !(set_o || clr_o));

    // R7: a power-good rise produces a pulse in the next cycle.
    p_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pg_i) |=> (set_o || clr_o));

    // R8: a change of level while powered always issues a pulse.
    p_edge_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pg_i && pg_q && level_i != lvl_q) |=> (set_o || clr_o));
endmodule

// File: rtl/edge_pulse_tx.sv
// Edge-pulse encoder: synchronizes a logic input, sends one-cycle set/clear
// pulses on its edges, refreshes the level after an idle interval, and is
// gated by power-good.
// Assumes: IDLE_CYCLES >= 4; SYNC_STAGES >= 2.
module edge_pulse_tx #(
    parameter int IDLE_CYCLES = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pwr_good_i,
    input  logic data_i,
    output logic set_pulse_o,
    output logic clr_pulse_o
);
    logic level;
    logic due;
    logic fire;

    ept_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (data_i),
        .q_o   (level)
    );

    ept_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (pwr_good_i),
        .restart_i(fire),
        .due_o    (due)
    );

    ept_pulse_gen u_gen (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pg_i     (pwr_good_i),
        .level_i  (level),
        .refresh_i(due),
        .fire_o   (fire),
        .set_o    (set_pulse_o),
        .clr_o    (clr_pulse_o)
    );
endmodule

// File: tb/edge_pulse_tx_tb_top.sv
// Directed bench for edge_pulse_tx, with IDLE_CYCLES = 8.
module edge_pulse_tx_tb_top;
    localparam int IDLE = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pg = 1'b0;
    logic din = 1'b0;
    logic set_p;
    logic clr_p;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    edge_pulse_tx #(.IDLE_CYCLES(IDLE), .SYNC_STAGES(2)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .pwr_good_i (pg),
        .data_i     (din),
        .set_pulse_o(set_p),
        .clr_pulse_o(clr_p)
    );

    task automatic check(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Sample n negedges; expect set at position s_at and clear at c_at (-1 = none).
    task automatic expect_win(input int n, input int s_at, input int c_at, input string req);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            check(set_p, logic'(i == s_at), req, "set");
            check(clr_p, logic'(i == c_at), req, "clr");
        end
    endtask

    // R9: outputs low during reset.
    task automatic t_reset();
        rst_n = 1'b0; pg = 1'b0; din = 1'b0;
        expect_win(4, -1, -1, "R9");
        rst_n = 1'b1;
        expect_win(2, -1, -1, "R9");
    endtask

    // R6 then R7: input ignored while unpowered, level sent at power-up.
    task automatic t_power_up();
        din = 1'b1;
        expect_win(5, -1, -1, "R6");
        pg = 1'b1;
        expect_win(1, 1, -1, "R7");
    endtask

    // R4: refresh of level 1 repeats every IDLE cycles.
    task automatic t_refresh_high();
        expect_win(IDLE, IDLE, -1, "R4");
        expect_win(IDLE, IDLE, -1, "R4");
    endtask

    // R2 and R4: falling edge, then refresh of level 0.
    task automatic t_fall();
        din = 1'b0;
        expect_win(3, -1, 3, "R2");
        expect_win(IDLE, -1, IDLE, "R4");
    endtask

    // R1: rising edge.
    task automatic t_rise();
        din = 1'b1;
        expect_win(3, 3, -1, "R1");
    endtask

    // R5: an edge in mid-interval moves the next refresh.
    task automatic t_restart();
        expect_win(2, -1, -1, "R5");
        din = 1'b0;
        expect_win(3, -1, 3, "R5");
        expect_win(IDLE, -1, IDLE, "R5");
    endtask

    // R8: edge pulse lands on the refresh cycle.
    task automatic t_collide();
        expect_win(IDLE - 3, -1, -1, "R8");
        din = 1'b1;
        expect_win(3, 3, -1, "R8");
        expect_win(IDLE, IDLE, -1, "R8");
    endtask

    // R3: toggles on consecutive cycles give separate one-cycle pulses.
    task automatic t_fast_toggle();
        din = 1'b0;
        expect_win(1, -1, -1, "R3");
        din = 1'b1;
        expect_win(3, 3, 2, "R3");
        expect_win(2, -1, -1, "R3");
    endtask

    // R6 then R7: power loss silences edges and refresh; restore sends level 0.
    task automatic t_power_cycle();
        pg = 1'b0;
        expect_win(5, -1, -1, "R6");
        din = 1'b0;
        expect_win(2 * IDLE, -1, -1, "R6");
        pg = 1'b1;
        expect_win(1, -1, 1, "R7");
        expect_win(IDLE, -1, IDLE, "R4");
    endtask

    initial begin
        t_reset();
        t_power_up();
        t_refresh_high();
        t_fall();
        t_rise();
        t_restart();
        t_collide();
        t_fast_toggle();
        t_power_cycle();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule